// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is a single output cell of a sum-of-products programmable logic device. It takes a vector of product-term results from the AND array and ORs them into one sum. The number of terms is a parameter. The sum then goes one of two ways. In registered mode it is captured by a D flip-flop on the rising clock edge. In combinatorial mode it passes straight through. A per-cell polarity choice drives the pin either true or inverted. A dedicated product term gates the pin driver.

Two product terms are shared by every registered cell in the device:
- a clearing term, which empties the flip-flop at once, without waiting for a clock;
- a setting term, which fills the flip-flop on the next rising edge.

Both act on the stored bit and not on the pin. A cleared register with inverted polarity therefore shows as a high pin. The cell also returns a true and a complement copy of a feedback bit to the array. That bit comes from the register in registered mode and from the pin level in combinatorial mode.

The flip-flop is modelled as a two-state machine with states `Q_CLR` (stored 0) and `Q_SET` (stored 1):
- The clearing term forces `Q_CLR` asynchronously from either state.
- On a clock edge with the setting term high, either state goes to `Q_SET`.
- On any other edge, the state goes to `Q_SET` when the sum is 1 and to `Q_CLR` when it is 0. This gives the transitions `Q_CLR->Q_SET`, `Q_SET->Q_CLR` and the two self-loops.

The configuration pair `{cfg_mode, cfg_pol}` decodes into four output modes:
- `MODE_REG_INV` (00)
- `MODE_REG_TRUE` (01)
- `MODE_COMB_INV` (10)
- `MODE_COMB_TRUE` (11)

Top module: `pld_out_cell`

## Requirements
- R1: The sum is the OR of all `NUM_TERMS` entries of `terms` (supported widths 8, 10, 12, 14, 16); any single term at 1, at the lowest or highest index, makes the sum 1.
- R2: `pin_oe` equals `oe_term` in every mode; a 0 there marks the pin as high impedance and leaves `pin_val`, `fb_true` and `fb_comp` unchanged.
- R3: With `cfg_mode`=1 (combinatorial), `pin_val` is the sum when `cfg_pol`=1 (true) and its inverse when `cfg_pol`=0 (inverted), following `terms` with no clock edge.
- R4: With `cfg_mode`=0 (registered), the flip-flop captures the sum on each rising edge of `clk`, and `pin_val` is the stored bit when `cfg_pol`=1 and its inverse when `cfg_pol`=0.
- R5: While `ar_term` is 1, the stored bit is 0 at once, before any clock edge, and stays 0 across edges.
- R6: With `sp_term` at 1, the stored bit becomes 1 on the next rising edge, and not before it.
- R7: When `ar_term` and `sp_term` are both 1, the stored bit stays 0.
- R8: Clearing and setting act on the stored bit before polarity, so a cleared register in inverted registered mode drives `pin_val` to 1.
- R9: In registered mode `fb_true` is the stored bit and `fb_comp` is its inverse, whatever the polarity.
- R10: In combinatorial mode `fb_true` equals `pin_val` and `fb_comp` is its inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| terms | input | NUM_TERMS | Logic product-term results from the array |
| oe_term | input | 1 | Dedicated output-enable product term |
| ar_term | input | 1 | Shared asynchronous clearing term, active high |
| sp_term | input | 1 | Shared synchronous setting term, active high |
| cfg_pol | input | 1 | Polarity select: 1 true, 0 inverted |
| cfg_mode | input | 1 | Mode select: 0 registered, 1 combinatorial |
| pin_val | output | 1 | Level the pin driver would present |
| pin_oe | output | 1 | Pin driver enable; 0 means high impedance |
| fb_true | output | 1 | True feedback to the array |
| fb_comp | output | 1 | Complement feedback to the array |

## Verification
The clocked properties assume the clearing term is always held across at least one rising edge. They are disabled while it is high, so a clearing pulse that begins and ends inside one clock period would escape them. The stimulus therefore raises and lowers `ar_term` only on falling edges or mid-period, and keeps it high through the following rising edge. The checks also assume `cfg_mode`, `cfg_pol` and `terms` change only away from the rising edge. The bench drives every input on the falling edge, and during the no-clock probe it drives them a quarter period after it, so the sampled values are always settled.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    typedef enum logic {
        Q_CLR = 1'b0,
        Q_SET = 1'b1
    } q_state_e;

    typedef enum logic [1:0] {
        MODE_REG_INV   = 2'b00,
        MODE_REG_TRUE  = 2'b01,
        MODE_COMB_INV  = 2'b10,
        MODE_COMB_TRUE = 2'b11
    } cell_mode_e;

    function automatic cell_mode_e decode_mode(input logic mode_bit, input logic pol_bit);
        return cell_mode_e'({mode_bit, pol_bit});
    endfunction

endpackage

// File: rtl/pld_term_or.sv
module pld_term_or #(
    parameter int NUM_TERMS = 16
) (
    input  logic [NUM_TERMS-1:0] terms,
    output logic                 sum
);
    localparam int CHAIN_W = NUM_TERMS + 1;

    logic [CHAIN_W-1:0] chain;

    assign chain[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TERMS; gi++) begin : g_or
            assign chain[gi+1] = chain[gi] | terms[gi];
        end
    endgenerate

    assign sum = chain[CHAIN_W-1];
endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg
    import pld_cell_pkg::*;
(
    input  logic clk,
    input  logic clr_async,
    input  logic set_sync,
    input  logic d_in,
    output logic q_out
);
    q_state_e state_q;
    q_state_e state_d;

    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async) begin
            state_q <= Q_CLR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_CLR: begin
                if (set_sync || d_in) state_d = Q_SET;
                else                  state_d = Q_CLR;
            end
            Q_SET: begin
                if (set_sync || d_in) state_d = Q_SET;
                else                  state_d = Q_CLR;
            end
            default: state_d = Q_CLR;
        endcase
    end

    always_comb begin
        q_out = (state_q == Q_SET);
    end
endmodule

// File: rtl/pld_out_stage.sv
module pld_out_stage
    import pld_cell_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       sum,
    input  logic       q_bit,
    input  logic       oe_term,
    output logic       pin_val,
    output logic       pin_oe,
    output logic       fb_true,
    output logic       fb_comp
);
    always_comb begin
        pin_val = 1'b0;
        fb_true = 1'b0;
        unique case (mode)
            MODE_REG_INV: begin
                pin_val = ~q_bit;
                fb_true = q_bit;
            end
            MODE_REG_TRUE: begin
                pin_val = q_bit;
                fb_true = q_bit;
            end
            MODE_COMB_INV: begin
                pin_val = ~sum;
                fb_true = ~sum;
            end
            MODE_COMB_TRUE: begin
                pin_val = sum;
                fb_true = sum;
            end
            default: begin
                pin_val = 1'b0;
                fb_true = 1'b0;
            end
        endcase
        fb_comp = ~fb_true;
        pin_oe  = oe_term;
    end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_cell_pkg::*;
#(
    parameter int NUM_TERMS = 16
) (
    input  logic                 clk,
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 oe_term,
    input  logic                 ar_term,
    input  logic                 sp_term,
    input  logic                 cfg_pol,
    input  logic                 cfg_mode,
    output logic                 pin_val,
    output logic                 pin_oe,
    output logic                 fb_true,
    output logic                 fb_comp
);
    logic       sum;
    logic       q_bit;
    cell_mode_e mode;

    assign mode = decode_mode(cfg_mode, cfg_pol);

    pld_term_or #(
        .NUM_TERMS(NUM_TERMS)
    ) u_or (
        .terms(terms),
        .sum  (sum)
    );

    pld_cell_reg u_reg (
        .clk      (clk),
        .clr_async(ar_term),
        .set_sync (sp_term),
        .d_in     (sum),
        .q_out    (q_bit)
    );

    pld_out_stage u_out (
        .mode   (mode),
        .sum    (sum),
        .q_bit  (q_bit),
        .oe_term(oe_term),
        .pin_val(pin_val),
        .pin_oe (pin_oe),
        .fb_true(fb_true),
        .fb_comp(fb_comp)
    );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
    parameter int NUM_TERMS = 16
) (
    input logic                 clk,
    input logic [NUM_TERMS-1:0] terms,
    input logic                 oe_term,
    input logic                 ar_term,
    input logic                 sp_term,
    input logic                 cfg_pol,
    input logic                 cfg_mode,
    input logic                 pin_val,
    input logic                 pin_oe,
    input logic                 fb_true,
    input logic                 fb_comp,
    input logic                 q_bit
);
    // R2
    oe_follow_chk: assert property (@(posedge clk) disable iff (ar_term)
        pin_oe == oe_term);

    // R4
    reg_capture_chk: assert property (@(posedge clk) disable iff (ar_term)
        (!sp_term && !cfg_mode) |=> (cfg_mode || (fb_true == $past(|terms))));

    // R5
    clear_hold_chk: assert property (@(posedge clk)
        ar_term |-> !q_bit);

    // R6
    preset_edge_chk: assert property (@(posedge clk) disable iff (ar_term)
        (sp_term && !cfg_mode) |=> (cfg_mode || fb_true));

    // R8
    clear_pin_chk: assert property (@(posedge clk)
        (ar_term && !cfg_mode && !cfg_pol) |-> pin_val);

    // R9
    reg_fb_chk: assert property (@(posedge clk) disable iff (ar_term)
        !cfg_mode |-> (fb_true == q_bit && fb_comp == !q_bit));

    // R10
    comb_fb_chk: assert property (@(posedge clk) disable iff (ar_term)
        cfg_mode |-> (fb_true == pin_val && fb_comp == !pin_val));
endmodule

bind pld_out_cell pld_out_cell_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (
    .clk     (clk),
    .terms   (terms),
    .oe_term (oe_term),
    .ar_term (ar_term),
    .sp_term (sp_term),
    .cfg_pol (cfg_pol),
    .cfg_mode(cfg_mode),
    .pin_val (pin_val),
    .pin_oe  (pin_oe),
    .fb_true (fb_true),
    .fb_comp (fb_comp),
    .q_bit   (q_bit)
);

// File: tb/pld_out_cell_tb.sv
module pld_out_cell_tb;
    localparam int NT = 16;
    localparam int NV = 10;

    // {mode, pol, oe, terms[15:0], exp_pin, exp_oe, exp_fb}
    localparam logic [21:0] VECS [NV] = '{
        {1'b1, 1'b1, 1'b1, 16'h0001, 1'b1, 1'b1, 1'b1},
        {1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1},
        {1'b0, 1'b1, 1'b1, 16'h0100, 1'b1, 1'b1, 1'b1},
        {1'b0, 1'b0, 1'b1, 16'h0100, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 16'h0020, 1'b1, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic [NT-1:0] terms = '0;
    logic          oe_term = 1'b1;
    logic          ar_term = 1'b1;
    logic          sp_term = 1'b0;
    logic          cfg_pol = 1'b1;
    logic          cfg_mode = 1'b0;
    logic          pin_val, pin_oe, fb_true, fb_comp;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    pld_out_cell #(.NUM_TERMS(NT)) u_dut (
        .clk     (clk),
        .terms   (terms),
        .oe_term (oe_term),
        .ar_term (ar_term),
        .sp_term (sp_term),
        .cfg_pol (cfg_pol),
        .cfg_mode(cfg_mode),
        .pin_val (pin_val),
        .pin_oe  (pin_oe),
        .fb_true (fb_true),
        .fb_comp (fb_comp)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic e_pin, input logic e_oe, input logic e_fb);
        check(req, "pin_val", pin_val, e_pin);
        check(req, "pin_oe", pin_oe, e_oe);
        check(req, "fb_true", fb_true, e_fb);
        check(req, "fb_comp", fb_comp, ~e_fb);
    endtask

    initial begin
        // Reset state: R5, registered true polarity
        repeat (2) @(posedge clk);
        #1;
        check_all("R5", 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        ar_term = 1'b0;

        // Vector table: R1 R2 R3 R4 R9 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cfg_mode, cfg_pol, oe_term, terms} = VECS[i][21:3];
            @(posedge clk);
            #1;
            check_all($sformatf("R1/R2/R3/R4/R9/R10 vec%0d", i),
                      VECS[i][2], VECS[i][1], VECS[i][0]);
        end

        // R3: combinatorial output follows terms with no clock edge
        @(negedge clk);
        cfg_mode = 1'b1; cfg_pol = 1'b1; oe_term = 1'b1; terms = '0;
        #1;
        terms = 16'h0400;
        #0.5;
        check("R3", "pin no clock", pin_val, 1'b1);

        // R5: asynchronous clear mid-cycle, registered mode holding 1
        @(negedge clk);
        cfg_mode = 1'b0; cfg_pol = 1'b1; terms = 16'h0004;
        @(posedge clk);
        #1;
        check("R4", "loaded 1", fb_true, 1'b1);
        ar_term = 1'b1;
        #0.5;
        check("R5", "clear before edge", fb_true, 1'b0);
        @(posedge clk);
        #1;
        check("R5", "clear held over edge", fb_true, 1'b0);
        // R8: cleared register, inverted polarity, pin high
        cfg_pol = 1'b0;
        #0.5;
        check("R8", "pin after clear inverted", pin_val, 1'b1);

        // R7: clear and preset together over an edge
        sp_term = 1'b1;
        @(posedge clk);
        #1;
        check("R7", "clear wins over preset", fb_true, 1'b0);
        @(negedge clk);
        ar_term = 1'b0; sp_term = 1'b0; terms = '0; cfg_pol = 1'b1;
        @(posedge clk);
        #1;

        // R6: preset waits for the edge
        @(negedge clk);
        sp_term = 1'b1;
        #1;
        check("R6", "no set before edge", fb_true, 1'b0);
        @(posedge clk);
        #1;
        check("R6", "set at edge", fb_true, 1'b1);
        // R8: set register inverted shows low
        cfg_pol = 1'b0;
        #0.5;
        check("R8", "pin after set inverted", pin_val, 1'b0);
        @(negedge clk);
        sp_term = 1'b0; cfg_pol = 1'b1;
        @(posedge clk);
        #1;
        check("R4", "reload 0 after preset", fb_true, 1'b0);

        // R2: disabled driver leaves value alone
        @(negedge clk);
        cfg_mode = 1'b1; cfg_pol = 1'b1; terms = 16'h0001; oe_term = 1'b0;
        #1;
        check("R2", "oe low", pin_oe, 1'b0);
        check("R2", "value kept", pin_val, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule